// File: doc/BRIEF.md
# Maskable Port Transition Detector

This block watches seven synchronized GPIO input levels (the ports numbered 24 through 30) for changes of logic state. A host-written mask word selects which of the seven are watched. The first time a watched port differs from a stored baseline of levels, the block raises one sticky flag. If the host asks for it, the same condition also drives an active-high interrupt out on port 31. When the interrupt is not in use, port 31 keeps working as an ordinary GPIO.

The baseline is captured when monitoring is switched on. It is captured again each time the host reads the status. That read also clears the flag and the interrupt. Shutdown and a disabled monitor both hold the detector idle. When either condition ends, a fresh baseline is taken.

The controller has three states:
- `TD_IDLE`: monitoring is off, or the block is in shutdown.
- `TD_WATCH`: armed, with no change seen yet.
- `TD_HIT`: a change has been flagged.

The transitions are:
- *arm*: `TD_IDLE` to `TD_WATCH` once the block is enabled and not in shutdown. The baseline is loaded on the same edge.
- *detect*: `TD_WATCH` to `TD_HIT` when a watched port differs from the baseline.
- *reread*: `TD_WATCH` stays in `TD_WATCH` on a read, and the baseline is reloaded.
- *acknowledge*: `TD_HIT` to `TD_WATCH` on a read, and the baseline is reloaded.
- *drop*: any state to `TD_IDLE` when the block is disabled or in shutdown.

Top module: `port_transition_detector`

## Requirements
- R1: While reset is asserted, and after it is released, `flag_o` and `irq_o` are 0.
- R2: While monitoring is active, suppose an unmasked port level differs from the baseline at a rising edge. Then `flag_o` reads 1 right after that edge. Bit i of `port_lvl_i` is port 24+i.
- R3: A port whose `watch_mask_i` bit is 1 is ignored, and its changes never set the flag. A mask bit of 0 means the port is watched.
- R4: Once set, the flag stays 1 until the host reads the status, even if the ports return to their baseline levels.
- R5: A read (`status_rd_i` high for one cycle) clears the flag after that edge and makes the current levels the new baseline. A change that is already present at the read edge is absorbed into the new baseline and is not flagged.
- R6: On the edge where monitoring becomes active, the current levels become the baseline. Levels present at that edge are never flagged.
- R7: While `mon_en_i` is 0, `flag_o` and `irq_o` are 0. Port 31 also carries `gp31_val_i` and `gp31_oe_i` unchanged in that case.
- R8: While `shutdown_i` is 1, no change is flagged and any set flag is cleared. When shutdown ends, a new baseline is taken.
- R9: `irq_o` equals `flag_o AND irq_en_i` (active high). While both `mon_en_i` and `irq_en_i` are 1, port 31 is driven (`p31_oe_o` = 1) with `p31_val_o` = `irq_o`.
- R10: Any combination of mask bits is accepted. Several simultaneous changes still set the single flag once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_lvl_i | input | 7 | Synchronized levels of ports 24..30 (bit 0 = port 24) |
| watch_mask_i | input | 7 | 1 = ignore this port |
| mon_en_i | input | 1 | Transition monitoring enable |
| irq_en_i | input | 1 | Drive interrupt onto port 31 |
| shutdown_i | input | 1 | Device in shutdown |
| status_rd_i | input | 1 | One-cycle strobe: host read of the status |
| gp31_val_i | input | 1 | GPIO output value for port 31 |
| gp31_oe_i | input | 1 | GPIO output enable for port 31 |
| flag_o | output | 1 | Sticky transition flag |
| irq_o | output | 1 | Interrupt request, active high |
| p31_val_o | output | 1 | Value driven on port 31 |
| p31_oe_o | output | 1 | Output enable for port 31 |

## Verification
The properties assume that the port levels have already been synchronized and change only between clock edges. They also assume that a read is a single-cycle strobe, sampled with the other inputs at the rising edge. The bench changes every input shortly after the falling edge. It raises `status_rd_i` for one cycle per read. Its random phase alters only a few port bits at a time, so that both the flagged path and the masked path occur often.

// File: rtl/tdet_pkg.sv
package tdet_pkg;
    localparam int TDET_PORTS = 7;

    typedef enum logic [1:0] {
        TD_IDLE  = 2'd0,
        TD_WATCH = 2'd1,
        TD_HIT   = 2'd2
    } tdet_state_e;
endpackage

// File: rtl/tdet_snap.sv
module tdet_snap #(
    parameter int NP = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [NP-1:0] lvl_i,
    input  logic [NP-1:0] mask_i,
    output logic          hit_o
);
    logic [NP-1:0] base_q;
    logic [NP-1:0] diff;

    always_ff @(posedge clk) begin
        if (!rst_n)      base_q <= '0;
        else if (load_i) base_q <= lvl_i;
    end

    // a watched bit that no longer matches the baseline
    always_comb diff = (lvl_i ^ base_q) & ~mask_i;
    assign hit_o = |diff;
endmodule

// File: rtl/tdet_fsm.sv
module tdet_fsm
    import tdet_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic rd_i,
    input  logic hit_i,
    input  logic irq_en_i,
    output logic load_o,
    output logic flag_o,
    output logic irq_o
);
    tdet_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        load_o  = 1'b0;
        unique case (state_q)
            TD_IDLE: begin
                if (active_i) begin            // arm
                    state_d = TD_WATCH;
                    load_o  = 1'b1;
                end
            end
            TD_WATCH: begin
                if (!active_i) begin           // drop
                    state_d = TD_IDLE;
                end else if (rd_i) begin       // reread
                    load_o  = 1'b1;
                end else if (hit_i) begin      // detect
                    state_d = TD_HIT;
                end
            end
            TD_HIT: begin
                if (!active_i) begin           // drop
                    state_d = TD_IDLE;
                end else if (rd_i) begin       // acknowledge
                    state_d = TD_WATCH;
                    load_o  = 1'b1;
                end
            end
            default: state_d = TD_IDLE;
        endcase
    end

    always_comb begin
        flag_o = (state_q == TD_HIT);
        irq_o  = flag_o & irq_en_i;
    end
endmodule

// File: rtl/tdet_p31_mux.sv
module tdet_p31_mux #(
    parameter bit IRQ_ON_PIN = 1'b1
) (
    input  logic sel_i,
    input  logic irq_i,
    input  logic gp_val_i,
    input  logic gp_oe_i,
    output logic val_o,
    output logic oe_o
);
    generate
        if (IRQ_ON_PIN) begin : g_shared
            assign val_o = sel_i ? irq_i : gp_val_i;
            assign oe_o  = sel_i | gp_oe_i;
        end else begin : g_gpio_only
            logic unused_sel;
            assign unused_sel = sel_i ^ irq_i;
            assign val_o = gp_val_i;
            assign oe_o  = gp_oe_i;
        end
    endgenerate
endmodule

// File: rtl/port_transition_detector.sv
module port_transition_detector #(
    parameter int NP         = tdet_pkg::TDET_PORTS,
    parameter bit IRQ_ON_PIN = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NP-1:0] port_lvl_i,
    input  logic [NP-1:0] watch_mask_i,
    input  logic          mon_en_i,
    input  logic          irq_en_i,
    input  logic          shutdown_i,
    input  logic          status_rd_i,
    input  logic          gp31_val_i,
    input  logic          gp31_oe_i,
    output logic          flag_o,
    output logic          irq_o,
    output logic          p31_val_o,
    output logic          p31_oe_o
);
    logic active, load, hit;

    assign active = mon_en_i & ~shutdown_i;

    tdet_snap #(.NP(NP)) u_snap (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .lvl_i  (port_lvl_i),
        .mask_i (watch_mask_i),
        .hit_o  (hit)
    );

    tdet_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (active),
        .rd_i     (status_rd_i),
        .hit_i    (hit),
        .irq_en_i (irq_en_i),
        .load_o   (load),
        .flag_o   (flag_o),
        .irq_o    (irq_o)
    );

    tdet_p31_mux #(.IRQ_ON_PIN(IRQ_ON_PIN)) u_p31 (
        .sel_i    (mon_en_i & irq_en_i),
        .irq_i    (irq_o),
        .gp_val_i (gp31_val_i),
        .gp_oe_i  (gp31_oe_i),
        .val_o    (p31_val_o),
        .oe_o     (p31_oe_o)
    );
endmodule

// File: rtl/port_transition_detector_chk.sv
module port_transition_detector_chk (
    input logic clk,
    input logic rst_n,
    input logic mon_en_i,
    input logic irq_en_i,
    input logic shutdown_i,
    input logic status_rd_i,
    input logic gp31_val_i,
    input logic gp31_oe_i,
    input logic flag_o,
    input logic irq_o,
    input logic p31_val_o,
    input logic p31_oe_o
);
    AST_IRQ_FOLLOWS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (flag_o && irq_en_i)); // R9

    AST_PIN_CARRIES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_en_i && irq_en_i) |-> (p31_oe_o && p31_val_o == irq_o)); // R9

    AST_PIN_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_en_i |-> (p31_oe_o == gp31_oe_i && p31_val_o == gp31_val_i)); // R7

    AST_IDLE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_en_i |=> !flag_o); // R7

    AST_SHUTDOWN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_i |=> !flag_o); // R8

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        status_rd_i |=> !flag_o); // R5

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !status_rd_i && mon_en_i && !shutdown_i) |=> flag_o); // R4

    AST_RISE_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(mon_en_i && !shutdown_i && !status_rd_i)); // R2
endmodule

bind port_transition_detector port_transition_detector_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mon_en_i    (mon_en_i),
    .irq_en_i    (irq_en_i),
    .shutdown_i  (shutdown_i),
    .status_rd_i (status_rd_i),
    .gp31_val_i  (gp31_val_i),
    .gp31_oe_i   (gp31_oe_i),
    .flag_o      (flag_o),
    .irq_o       (irq_o),
    .p31_val_o   (p31_val_o),
    .p31_oe_o    (p31_oe_o)
);

// File: tb/port_transition_detector_tb_top.sv
`timescale 1ns/1ps
module port_transition_detector_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] lvl = 7'h00, mask = 7'h00;
    logic       mon = 1'b0, ien = 1'b0, sd = 1'b0, rd = 1'b0;
    logic       gval = 1'b0, goe = 1'b0;
    logic       flag, irq, pval, poe;

    int    n_chk = 0, n_fail = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // reference state
    bit       m_on = 0, m_flag = 0;
    bit [6:0] m_base = '0;

    always #2.5 clk = ~clk;

    port_transition_detector dut_i (
        .clk(clk), .rst_n(rst_n), .port_lvl_i(lvl), .watch_mask_i(mask),
        .mon_en_i(mon), .irq_en_i(ien), .shutdown_i(sd), .status_rd_i(rd),
        .gp31_val_i(gval), .gp31_oe_i(goe),
        .flag_o(flag), .irq_o(irq), .p31_val_o(pval), .p31_oe_o(poe)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_on = 0; m_flag = 0; m_base = '0;
        end else if (!mon || sd) begin
            m_on = 0; m_flag = 0;
        end else if (!m_on) begin
            m_on = 1; m_flag = 0; m_base = lvl;
        end else if (rd) begin
            m_flag = 0; m_base = lvl;
        end else if (((lvl ^ m_base) & ~mask) != 0) begin
            m_flag = 1;
        end
    end

    task automatic chk(string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            bit e_irq, e_oe, e_val;
            e_irq = m_flag && ien;
            e_oe  = (mon && ien) ? 1'b1 : goe;
            e_val = (mon && ien) ? e_irq : gval;
            chk("flag_o", flag, m_flag);
            chk("irq_o", irq, e_irq);
            chk("p31_oe_o", poe, e_oe);
            chk("p31_val_o", pval, e_val);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic do_read();
        rd = 1'b1; cyc(1); rd = 1'b0;
    endtask

    task automatic expect_flag(string req, bit e);
        @(negedge clk);
        cur_req = req;
        chk("flag_o explicit", flag, e);
        #1;
    endtask

    initial begin
        cur_req = "R1";
        cyc(3);
        chk("flag_o in reset", flag, 1'b0);
        chk("irq_o in reset", irq, 1'b0);
        rst_n = 1'b1; cyc(2);
        // R6: baseline taken at enable
        cur_req = "R6";
        lvl = 7'h55; mon = 1'b1; ien = 1'b1; cyc(1);
        expect_flag("R6", 0);
        // R2: unmasked change flags
        cur_req = "R2";
        lvl = 7'h51; cyc(1);
        expect_flag("R2", 1);
        // R4: sticky after return
        cur_req = "R4";
        lvl = 7'h55; cyc(3);
        expect_flag("R4", 1);
        // R5: read clears, new baseline
        cur_req = "R5";
        do_read();
        expect_flag("R5", 0);
        lvl = 7'h54; rd = 1'b1; cyc(1); rd = 1'b0;
        expect_flag("R5", 0);
        cyc(2);
        // R3: masked port ignored
        cur_req = "R3";
        mask = 7'h0F; lvl = 7'h56; cyc(3);
        expect_flag("R3", 0);
        lvl = 7'h76; cyc(1);
        expect_flag("R3", 1);
        // R9: interrupt gating and pin
        cur_req = "R9";
        ien = 1'b0; gval = 1'b1; goe = 1'b0; cyc(2);
        ien = 1'b1; cyc(2);
        do_read(); cyc(1);
        // R7: disabled
        cur_req = "R7";
        mon = 1'b0; mask = 7'h00;
        for (int i = 0; i < 8; i++) begin
            lvl = 7'(i * 13); gval = i[0]; goe = i[1]; cyc(1);
        end
        expect_flag("R7", 0);
        // R8: shutdown
        cur_req = "R8";
        mon = 1'b1; cyc(2);
        lvl = 7'h7F; cyc(1);
        expect_flag("R8", 1);
        sd = 1'b1; cyc(1);
        lvl = 7'h00; cyc(3);
        expect_flag("R8", 0);
        sd = 1'b0; cyc(3);
        expect_flag("R8", 0);
        // R10: random mask/level/read mix
        cur_req = "R10";
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 3) == 0) lvl = lvl ^ 7'(1 << $urandom_range(0, 6));
            if ($urandom_range(0, 15) == 0) mask = 7'($urandom);
            rd  = ($urandom_range(0, 9) == 0);
            ien = ($urandom_range(0, 7) != 0);
            if ($urandom_range(0, 63) == 0) mon = ~mon;
            if ($urandom_range(0, 63) == 0) sd = ~sd;
            gval = $urandom_range(0, 1); goe = $urandom_range(0, 1);
            cyc(1);
        end
        rd = 1'b0; cyc(2);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule